// File: doc/BRIEF.md
# Hardware stack with sticky error flags

This block is the system stack of a processor core. It has sixteen entries, and each entry holds a high word and a low word. A pointer register of six bits tracks the stack: a four-bit pointer to the last used entry, a stack-error flag and an underflow flag. A push first advances the pointer and then stores the data at the new location. A pull leaves the current top on the outputs and then moves the pointer back. A double request moves the pointer by two in one cycle. On a double push, the first data pair lands one entry above the old top and the second pair lands two entries above it.

The top entry is always presented on the outputs. A top-of-stack write replaces the current top without moving the pointer. Software can load the pointer register directly, and that load is the only way to clear the error flag. An overflow or underflow is encoded by letting the pointer wrap into the two flag bits. When the error flag goes from 0 to 1, the block emits a one-cycle exception request, which the core routes at priority level 3.

Top module: `sys_stack`

## Requirements
- R1: After reset, the register read value is 0, the exception output is low, and the top entry reads zero in both words.
- R2: A single push with error clear increments the pointer and makes the pushed pair the top from the next cycle. A single pull decrements the pointer.
- R3: A double push places its first pair at pointer+1 and its second pair at pointer+2, and the pointer rises by 2. A double pull lowers the pointer by 2.
- R4: A push at pointer 15 with error clear makes the register read 0x10, and a double push from 15 makes it read 0x11 (bit 4 = error, bit 5 = underflow, bits 3:0 = pointer).
- R5: A pull at pointer 0 with error clear makes the register read 0x3F, and a double pull from 0 makes it read 0x3E.
- R6: The exception output is high for exactly the one cycle in which bit 4 first reads 1 after reading 0. This includes a software load that sets bit 4.
- R7: Once bit 4 is set, pushes and pulls leave it set. Only a software load with bit 4 = 0 clears it.
- R8: While bit 4 is set, bit 5 is not changed by pushes or pulls. The pointer bits still move, modulo 16.
- R9: A top-of-stack write replaces the top entry and leaves the register value unchanged, even at pointer 0. Reading the top entry has no side effect.
- R10: If software loads bit 5 = 1 with bit 4 = 0, the next push or pull recomputes both flags from the pointer arithmetic alone.
- R11: Register bits 23:6 always read 0, and a software load ignores bits 23:6 of its write data.
- R12: In one cycle, a software load takes priority over a push, a push over a pull, and a pull over a top-of-stack write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push request |
| pull_i | input | 1 | Pull request |
| dbl_i | input | 1 | Makes the push or pull a double one |
| tos_wr_i | input | 1 | Write the top entry in place |
| wr_hi_i | input | HI_W | High word for a push (first pair) or a top write |
| wr_lo_i | input | LO_W | Low word for a push (first pair) or a top write |
| wr2_hi_i | input | HI_W | High word of the second pair of a double push |
| wr2_lo_i | input | LO_W | Low word of the second pair of a double push |
| sw_wr_i | input | 1 | Software load of the pointer register |
| sw_wdata_i | input | RD_W | Software load value |
| top_hi_o | output | HI_W | High word of the entry at the pointer |
| top_lo_o | output | LO_W | Low word of the entry at the pointer |
| sp_rd_o | output | RD_W | Pointer register read value |
| exc_o | output | 1 | One-cycle stack-error exception request |

## Verification
The properties take the request inputs to be synchronous with the clock and stable around its edge. Several request lines may be high in the same cycle, and the properties that expect a pointer step state the priority they assume in their antecedent. The stimulus combines requests on purpose to reach the priority cases. It drives every case that involves a flag, either from a software load of a chosen register value or from a walk to an empty or full stack. Every case is compared against a behavioural model that uses plain integer pointer arithmetic.

// File: rtl/sys_stack_pkg.sv
`timescale 1ns/1ps
package sys_stack_pkg;
  localparam int unsigned PTR_W   = 4;
  localparam int unsigned DEPTH   = 1 << PTR_W;
  localparam int unsigned SP_W    = PTR_W + 2;
  localparam int unsigned ERR_BIT = PTR_W;
  localparam int unsigned UNF_BIT = PTR_W + 1;

  typedef logic [SP_W-1:0] sp_t;
  typedef enum logic [2:0] {OP_IDLE, OP_SW, OP_PUSH, OP_PULL, OP_TOS} op_e;

  // Signed 3-bit step: +1/+2 when up, -1/-2 otherwise.
  function automatic logic [2:0] step_amount(input logic up, input logic dbl);
    if (up) step_amount = dbl ? 3'b010 : 3'b001;
    else    step_amount = dbl ? 3'b110 : 3'b111;
  endfunction

  // Pointer move with the flag bits catching the wrap.
  function automatic sp_t sp_step(input sp_t cur, input logic [2:0] delta);
    sp_t d;
    sp_t v;
    d = {{(SP_W-3){delta[2]}}, delta};
    v = {2'b00, cur[PTR_W-1:0]} + d;
    sp_step = {cur[ERR_BIT] ? cur[UNF_BIT] : v[UNF_BIT],
               cur[ERR_BIT] | v[ERR_BIT],
               v[PTR_W-1:0]};
  endfunction
endpackage

// File: rtl/sys_stack_ptr.sv
`timescale 1ns/1ps
module sys_stack_ptr
  import sys_stack_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  op_e  op,
  input  logic dbl,
  input  sp_t  sw_val,
  output sp_t  sp_q,
  output logic exc_q
);
  sp_t  sp_nx;
  logic err_rise;

  always_comb begin
    unique case (op)
      OP_SW:   sp_nx = sw_val;
      OP_PUSH: sp_nx = sp_step(sp_q, step_amount(1'b1, dbl));
      OP_PULL: sp_nx = sp_step(sp_q, step_amount(1'b0, dbl));
      default: sp_nx = sp_q;
    endcase
  end

  assign err_rise = ~sp_q[ERR_BIT] & sp_nx[ERR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q  <= '0;
      exc_q <= 1'b0;
    end else begin
      sp_q  <= sp_nx;
      exc_q <= err_rise;
    end
  end
endmodule

// File: rtl/sys_stack_ram.sv
`timescale 1ns/1ps
module sys_stack_ram #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned HI_W  = 16,
  parameter int unsigned LO_W  = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_a,
  input  logic [IDX_W-1:0] idx_a,
  input  logic [HI_W-1:0]  hi_a,
  input  logic [LO_W-1:0]  lo_a,
  input  logic             we_b,
  input  logic [IDX_W-1:0] idx_b,
  input  logic [HI_W-1:0]  hi_b,
  input  logic [LO_W-1:0]  lo_b,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [HI_W-1:0]  rd_hi,
  output logic [LO_W-1:0]  rd_lo
);
  logic [HI_W-1:0] ent_hi [DEPTH];
  logic [LO_W-1:0] ent_lo [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    logic hit_a, hit_b;
    assign hit_a = we_a && (idx_a == MY_IDX);
    assign hit_b = we_b && (idx_b == MY_IDX);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_hi[g] <= '0;
        ent_lo[g] <= '0;
      end else if (hit_b) begin
        ent_hi[g] <= hi_b;
        ent_lo[g] <= lo_b;
      end else if (hit_a) begin
        ent_hi[g] <= hi_a;
        ent_lo[g] <= lo_a;
      end
    end
  end

  assign rd_hi = ent_hi[rd_idx];
  assign rd_lo = ent_lo[rd_idx];
endmodule

// File: rtl/sys_stack.sv
`timescale 1ns/1ps
module sys_stack
  import sys_stack_pkg::*;
#(
  parameter int unsigned HI_W = 16,
  parameter int unsigned LO_W = 16,
  parameter int unsigned RD_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  logic            pull_i,
  input  logic            dbl_i,
  input  logic            tos_wr_i,
  input  logic [HI_W-1:0] wr_hi_i,
  input  logic [LO_W-1:0] wr_lo_i,
  input  logic [HI_W-1:0] wr2_hi_i,
  input  logic [LO_W-1:0] wr2_lo_i,
  input  logic            sw_wr_i,
  input  logic [RD_W-1:0] sw_wdata_i,
  output logic [HI_W-1:0] top_hi_o,
  output logic [LO_W-1:0] top_lo_o,
  output logic [RD_W-1:0] sp_rd_o,
  output logic            exc_o
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);
  localparam logic [PTR_W-1:0] TWO = PTR_W'(2);

  op_e              op;
  sp_t              sp_q;
  logic [PTR_W-1:0] ptr;
  logic             we_a, we_b;
  logic [PTR_W-1:0] idx_a, idx_b;
  logic             unused_wdata;

  // Request priority: software load, push, pull, top write.
  always_comb begin
    if (sw_wr_i)       op = OP_SW;
    else if (push_i)   op = OP_PUSH;
    else if (pull_i)   op = OP_PULL;
    else if (tos_wr_i) op = OP_TOS;
    else               op = OP_IDLE;
  end

  sys_stack_ptr u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .dbl    (dbl_i),
    .sw_val (sw_wdata_i[SP_W-1:0]),
    .sp_q   (sp_q),
    .exc_q  (exc_o)
  );

  assign ptr   = sp_q[PTR_W-1:0];
  assign we_a  = (op == OP_PUSH) || (op == OP_TOS);
  assign idx_a = (op == OP_TOS) ? ptr : ptr + ONE;
  assign we_b  = (op == OP_PUSH) && dbl_i;
  assign idx_b = ptr + TWO;

  sys_stack_ram #(.DEPTH(DEPTH), .HI_W(HI_W), .LO_W(LO_W)) u_ram (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_a   (we_a),
    .idx_a  (idx_a),
    .hi_a   (wr_hi_i),
    .lo_a   (wr_lo_i),
    .we_b   (we_b),
    .idx_b  (idx_b),
    .hi_b   (wr2_hi_i),
    .lo_b   (wr2_lo_i),
    .rd_idx (ptr),
    .rd_hi  (top_hi_o),
    .rd_lo  (top_lo_o)
  );

  assign sp_rd_o      = {{(RD_W-SP_W){1'b0}}, sp_q};
  assign unused_wdata = ^sw_wdata_i[RD_W-1:SP_W];
endmodule

// File: rtl/sys_stack_chk.sv
`timescale 1ns/1ps
module sys_stack_chk #(
  parameter int unsigned RD_W = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            push_i,
  input logic            pull_i,
  input logic            dbl_i,
  input logic            tos_wr_i,
  input logic            sw_wr_i,
  input logic [RD_W-1:0] sw_wdata_i,
  input logic [RD_W-1:0] sp_rd_o,
  input logic            exc_o
);
  // R2
  push_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !sw_wr_i && !dbl_i) |=> (sp_rd_o[3:0] == $past(sp_rd_o[3:0]) + 4'd1));
  // R4
  overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !sw_wr_i && !sp_rd_o[4] && sp_rd_o[3:0] == 4'hF) |=> (sp_rd_o[5:4] == 2'b01));
  // R5
  underflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_i && !push_i && !sw_wr_i && sp_rd_o[5:0] == 6'd0) |=> (sp_rd_o[5:4] == 2'b11));
  // R6
  exc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_o |-> (sp_rd_o[4] && !$past(sp_rd_o[4])));
  // R6
  exc_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sp_rd_o[4]) |-> exc_o);
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_rd_o[4] && !sw_wr_i) |=> sp_rd_o[4]);
  // R8
  unf_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_rd_o[4] && !sw_wr_i) |=> $stable(sp_rd_o[5]));
  // R9
  tos_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tos_wr_i && !push_i && !pull_i && !sw_wr_i) |=> $stable(sp_rd_o[5:0]));
  // R11
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_i && sw_wdata_i[RD_W-1:6] != '0) |=> (sp_rd_o[RD_W-1:6] == '0));
  // R12
  sw_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_i |=> (sp_rd_o[5:0] == $past(sw_wdata_i[5:0])));
  // R3
  dbl_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && dbl_i && !sw_wr_i) |=> (sp_rd_o[3:0] == $past(sp_rd_o[3:0]) + 4'd2));
endmodule

bind sys_stack sys_stack_chk #(.RD_W(RD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .push_i     (push_i),
  .pull_i     (pull_i),
  .dbl_i      (dbl_i),
  .tos_wr_i   (tos_wr_i),
  .sw_wr_i    (sw_wr_i),
  .sw_wdata_i (sw_wdata_i),
  .sp_rd_o    (sp_rd_o),
  .exc_o      (exc_o)
);

// File: tb/sys_stack_bench.sv
`timescale 1ns/1ps
module sys_stack_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 0, pull_i = 0, dbl_i = 0, tos_wr_i = 0, sw_wr_i = 0;
  logic [15:0] wr_hi_i = 0, wr_lo_i = 0, wr2_hi_i = 0, wr2_lo_i = 0;
  logic [23:0] sw_wdata_i = 0;
  logic [15:0] top_hi_o, top_lo_o;
  logic [23:0] sp_rd_o;
  logic        exc_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // behavioural model
  int m_ptr = 0;
  bit m_err = 0, m_unf = 0, m_exc = 0;
  int m_hi[16];
  int m_lo[16];

  always #2.5 clk = ~clk;

  sys_stack u_sys_stack (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pull_i(pull_i), .dbl_i(dbl_i),
    .tos_wr_i(tos_wr_i), .wr_hi_i(wr_hi_i), .wr_lo_i(wr_lo_i),
    .wr2_hi_i(wr2_hi_i), .wr2_lo_i(wr2_lo_i), .sw_wr_i(sw_wr_i),
    .sw_wdata_i(sw_wdata_i), .top_hi_o(top_hi_o), .top_lo_o(top_lo_o),
    .sp_rd_o(sp_rd_o), .exc_o(exc_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int model_sp();
    return (int'(m_unf) << 5) | (int'(m_err) << 4) | m_ptr;
  endfunction

  task automatic compare(input string req);
    chk(req, "sp_rd", int'(sp_rd_o), model_sp());
    chk(req, "top_hi", int'(top_hi_o), m_hi[m_ptr]);
    chk(req, "top_lo", int'(top_lo_o), m_lo[m_ptr]);
    chk(req, "exc", int'(exc_o), int'(m_exc));
  endtask

  task automatic model_step(input bit sw, input int wd, input bit pu, input bit pl,
                            input bit db, input bit tw, input int h1, input int l1,
                            input int h2, input int l2);
    bit old_err;
    int raw;
    old_err = m_err;
    if (sw) begin
      m_ptr = wd & 15;
      m_err = ((wd >> 4) & 1) != 0;
      m_unf = ((wd >> 5) & 1) != 0;
    end else if (pu || pl) begin
      raw = m_ptr + (pu ? (db ? 2 : 1) : (db ? -2 : -1));
      if (pu) begin
        m_hi[(m_ptr + 1) % 16] = h1;
        m_lo[(m_ptr + 1) % 16] = l1;
        if (db) begin
          m_hi[(m_ptr + 2) % 16] = h2;
          m_lo[(m_ptr + 2) % 16] = l2;
        end
      end
      if (!m_err) begin
        m_err = (raw > 15) || (raw < 0);
        m_unf = (raw < 0);
      end
      m_ptr = (raw + 16) % 16;
    end else if (tw) begin
      m_hi[m_ptr] = h1;
      m_lo[m_ptr] = l1;
    end
    m_exc = !old_err && m_err;
  endtask

  // One clock: drive at the falling edge, model at the rising edge, compare at the next falling edge.
  task automatic op(input string req, input bit sw, input int wd, input bit pu,
                    input bit pl, input bit db, input bit tw,
                    input int h1 = 0, input int l1 = 0, input int h2 = 0, input int l2 = 0);
    sw_wr_i = sw; sw_wdata_i = 24'(wd); push_i = pu; pull_i = pl; dbl_i = db;
    tos_wr_i = tw; wr_hi_i = 16'(h1); wr_lo_i = 16'(l1); wr2_hi_i = 16'(h2); wr2_lo_i = 16'(l2);
    @(posedge clk);
    model_step(sw, wd, pu, pl, db, tw, h1, l1, h2, l2);
    @(negedge clk);
    sw_wr_i = 0; push_i = 0; pull_i = 0; dbl_i = 0; tos_wr_i = 0;
    compare(req);
  endtask

  task automatic idle(input string req);
    op(req, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_hi[i] = 0; m_lo[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1");
    chk("R1", "sp_rd reset", int'(sp_rd_o), 0);

    // R2 single push and pull
    op("R2", 0, 0, 1, 0, 0, 0, 'h1111, 'hA001);
    op("R2", 0, 0, 1, 0, 0, 0, 'h2222, 'hA002);
    op("R2", 0, 0, 1, 0, 0, 0, 'h3333, 'hA003);
    chk("R2", "sp after 3 pushes", int'(sp_rd_o), 3);
    chk("R2", "top after pushes", int'(top_hi_o), 'h3333);
    op("R2", 0, 0, 0, 1, 0, 0);
    chk("R2", "sp after pull", int'(sp_rd_o), 2);
    chk("R2", "top after pull", int'(top_lo_o), 'hA002);

    // R3 double push and pull
    op("R3", 0, 0, 1, 0, 1, 0, 'h4444, 'hB001, 'h5555, 'hB002);
    chk("R3", "sp after dbl push", int'(sp_rd_o), 4);
    chk("R3", "top after dbl push", int'(top_hi_o), 'h5555);
    op("R3", 0, 0, 0, 1, 1, 0);
    chk("R3", "sp after dbl pull", int'(sp_rd_o), 2);
    op("R3", 0, 0, 0, 0, 0, 0);

    // R12 priorities
    op("R12", 0, 0, 1, 1, 0, 0, 'h6666, 'hC001);
    chk("R12", "push over pull", int'(sp_rd_o), 3);
    op("R12", 1, 'h05, 1, 0, 0, 0, 'h7777, 'hC002);
    chk("R12", "sw over push", int'(sp_rd_o), 5);
    op("R12", 0, 0, 0, 1, 0, 1, 'h7878, 'hC003);
    chk("R12", "pull over tos", int'(sp_rd_o), 4);

    // R9 top write at empty stack
    op("R9", 1, 0, 0, 0, 0, 0);
    op("R9", 0, 0, 0, 0, 0, 1, 'h8888, 'hD001);
    chk("R9", "sp after tos write", int'(sp_rd_o), 0);
    chk("R9", "top after tos write", int'(top_hi_o), 'h8888);
    idle("R9");
    idle("R9");

    // R5 / R6 underflow
    op("R5", 0, 0, 0, 1, 0, 0);
    chk("R5", "sp after empty pull", int'(sp_rd_o), 'h3F);
    chk("R6", "exc pulse", int'(exc_o), 1);
    idle("R6");
    chk("R6", "exc one cycle", int'(exc_o), 0);

    // R7 / R8 sticky behaviour
    op("R7", 0, 0, 1, 0, 0, 0, 'h9999, 'hE001);
    chk("R8", "unf held after push", int'(sp_rd_o), 'h30);
    op("R7", 0, 0, 1, 0, 0, 0, 'h9A9A, 'hE002);
    chk("R7", "err held", int'(sp_rd_o), 'h31);
    op("R7", 0, 0, 0, 1, 0, 0);
    op("R7", 0, 0, 0, 1, 1, 0);
    chk("R6", "no second pulse", int'(exc_o), 0);
    op("R7", 1, 0, 0, 0, 0, 0);
    chk("R7", "cleared by sw", int'(sp_rd_o), 0);
    op("R5", 0, 0, 0, 1, 1, 0);
    chk("R5", "dbl pull empty", int'(sp_rd_o), 'h3E);

    // R4 overflow
    op("R4", 1, 'h0F, 0, 0, 0, 0);
    chk("R6", "no pulse on clear", int'(exc_o), 0);
    op("R4", 0, 0, 1, 0, 0, 0, 'hABCD, 'hF001);
    chk("R4", "push at full", int'(sp_rd_o), 'h10);
    op("R8", 0, 0, 0, 1, 0, 0);
    chk("R8", "unf frozen at 0", int'(sp_rd_o), 'h1F);
    op("R4", 1, 'h0F, 0, 0, 0, 0);
    op("R4", 0, 0, 1, 0, 1, 0, 'h1234, 'hF002, 'h5678, 'hF003);
    chk("R4", "dbl push at full", int'(sp_rd_o), 'h11);

    // R10 forced illegal flags
    op("R10", 1, 'h23, 0, 0, 0, 0);
    chk("R10", "forced value", int'(sp_rd_o), 'h23);
    op("R10", 0, 0, 1, 0, 0, 0, 'h0BAD, 'h0001);
    chk("R10", "corrected by push", int'(sp_rd_o), 'h04);
    op("R10", 1, 'h21, 0, 0, 0, 0);
    op("R10", 0, 0, 0, 1, 0, 0);
    chk("R10", "corrected by pull", int'(sp_rd_o), 'h00);

    // R11 upper bits
    op("R11", 1, 'hFFFFC5, 0, 0, 0, 0);
    chk("R11", "upper bits zero", int'(sp_rd_o), 'h05);

    // R6 software set
    op("R6", 1, 'h10, 0, 0, 0, 0);
    chk("R6", "sw set pulse", int'(exc_o), 1);
    idle("R6");

    done = 1;
    summary();
  end
endmodule